// File: doc/BRIEF.md
# Private Countdown Timer with Prescaler

This block is a single 32-bit down-counter. Software programs it through four word registers on a simple single-cycle bus: a reload value, the live count, a control word and an event flag. Once enabled, the counter drops by one on every tick. A programmable 8-bit divider sets the tick rate from the core clock. When the count reaches zero the event flag is raised. An interrupt line presents the flag whenever the interrupt-enable bit is set.

Two run styles exist. In one-shot style the count stops at zero. In auto-reload style the zero state lasts one tick, and the counter then restarts from the reload value, so one full period is reload+1 ticks. Zero values are handled with care. With the divider at zero, a zero reload or a zero count write halts the counter without raising an event. With a nonzero divider and a zero reload value, auto-reload raises the event on every tick.

Top module: `pcd_timer`

## Requirements
- R1: After synchronous reset, every register reads 0, the counter is stopped and `irq` is 0.
- R2: Byte offset 0x0 is the reload value, 0x4 the count, 0x8 control and 0xC the event flag (bit 0). Any other offset reads 0 and ignores writes. Control reads back run-enable at bit 0, auto-reload at bit 1, interrupt-enable at bit 2 and the divider at bits [15:8]; all other control bits read 0.
- R3: While running, the count decrements once every divider+1 clock cycles. The first tick falls divider+1 cycles after the write that started it.
- R4: `irq` is the event flag ANDed with interrupt-enable. Writing 1 to bit 0 of the flag register clears the flag, and `irq` follows on the next cycle.
- R5: In one-shot style, the tick that brings the count from 1 to 0 sets the flag and stops the counter at 0.
- R6: In auto-reload style with a nonzero reload value, reaching 0 sets the flag, and the next tick loads the reload value.
- R7: In auto-reload style with a reload value of 0, a nonzero divider sets the flag on every tick. A zero divider stops the counter after the one event that reaches 0.
- R8: The counter runs only while run-enable is set and either the divider or the starting count is nonzero. Writes made while disabled change the stored values but start nothing.
- R9: Writing 0 to the reload register while enabled with a zero divider stops the counter, and no event is raised.
- R10: Writing 0 to the count while enabled with a zero divider works as follows. In one-shot style, or when the reload value is 0, the counter stops with no event. In auto-reload style with a nonzero reload value, the count takes the reload value and keeps running.
- R11: A control write that enables auto-reload style while the count is 0 first loads the reload value into the count, then starts. Enabling one-shot style with count 0 and divider 0 leaves the counter stopped.
- R12: Writing the reload register also sets the count to the written value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Access strobe, one cycle per access |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte offset of the access |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, valid in the cycle of the read, 0 otherwise |
| irq | output | 1 | Event flag gated by interrupt-enable |

## Verification
A wrong tick phase shows up as a count readback that is off by one within divider+1 cycles of a start. A run bit that stays set shows up within one tick period as an event flag that appears again after a zero write, or after the counter should have stopped. A missed or doubled reload is visible in the count read back on the tick after zero. A bad flag or gating path is visible on `irq` the cycle after the control or clear write that changes it.

// File: rtl/pcd_timer_pkg.sv
package pcd_timer_pkg;

    localparam int unsigned DIV_W        = 8;
    localparam int unsigned CTRL_RUN_BIT = 0;
    localparam int unsigned CTRL_AUTO_BIT = 1;
    localparam int unsigned CTRL_IE_BIT  = 2;
    localparam int unsigned CTRL_DIV_LSB = 8;

    typedef enum logic [1:0] {
        SLOT_RELOAD = 2'd0,
        SLOT_COUNT  = 2'd1,
        SLOT_CTRL   = 2'd2,
        SLOT_FLAG   = 2'd3
    } slot_e;

    typedef struct packed {
        logic [DIV_W-1:0] div;
        logic             irq_en;
        logic             auto_rl;
        logic             run_en;
    } ctrl_t;

    typedef struct packed {
        logic reload;
        logic count;
        logic ctrl;
        logic flag;
    } wr_strb_t;

    function automatic ctrl_t ctrl_from_half(logic [15:0] w);
        ctrl_t c;
        c.run_en  = w[CTRL_RUN_BIT];
        c.auto_rl = w[CTRL_AUTO_BIT];
        c.irq_en  = w[CTRL_IE_BIT];
        c.div     = w[CTRL_DIV_LSB +: DIV_W];
        return c;
    endfunction

    function automatic logic [15:0] ctrl_to_half(ctrl_t c);
        logic [15:0] w;
        w = '0;
        w[CTRL_RUN_BIT]              = c.run_en;
        w[CTRL_AUTO_BIT]             = c.auto_rl;
        w[CTRL_IE_BIT]               = c.irq_en;
        w[CTRL_DIV_LSB +: DIV_W]     = c.div;
        return w;
    endfunction

    function automatic wr_strb_t strobes_for(logic hit, logic wr, slot_e s);
        wr_strb_t st;
        st        = '0;
        st.reload = hit && wr && (s == SLOT_RELOAD);
        st.count  = hit && wr && (s == SLOT_COUNT);
        st.ctrl   = hit && wr && (s == SLOT_CTRL);
        st.flag   = hit && wr && (s == SLOT_FLAG);
        return st;
    endfunction

endpackage

// File: rtl/pcd_prescale.sv
module pcd_prescale #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         run_i,
    input  logic         restart_i,
    input  logic [W-1:0] div_i,
    output logic         tick_o
);
    logic [W-1:0] phase_q;

    assign tick_o = run_i && !restart_i && (phase_q == div_i);

    always_ff @(posedge clk) begin
        if (rst || restart_i || !run_i || tick_o) begin
            phase_q <= '0;
        end else begin
            phase_q <= phase_q + 1'b1;
        end
    end

    // R3: the phase never passes the divider while counting
    assert_phase_bound_R3: assert property (@(posedge clk) disable iff (rst)
        (run_i && !restart_i) |-> (phase_q <= div_i));

    // R3: with a nonzero divider two ticks are never adjacent
    assert_tick_spacing_R3: assert property (@(posedge clk) disable iff (rst)
        (tick_o && div_i != '0) |=> !tick_o);

endmodule

// File: rtl/pcd_count_core.sv
module pcd_count_core
    import pcd_timer_pkg::*;
#(
    parameter int unsigned CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick_i,
    input  wr_strb_t         strb_i,
    input  logic [CNT_W-1:0] wdata_i,
    input  ctrl_t            ctrl_i,
    input  ctrl_t            ctrl_new_i,
    input  logic [CNT_W-1:0] reload_i,
    output logic [CNT_W-1:0] count_o,
    output logic             running_o,
    output logic             zero_evt_o
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    logic [CNT_W-1:0] count_q, cnt_n, wr_val, seed;
    logic             running_q, run_n, evt;
    logic             div_zero, new_div_zero;

    assign div_zero     = (ctrl_i.div == '0);
    assign new_div_zero = (ctrl_new_i.div == '0);

    always_comb begin
        cnt_n  = count_q;
        run_n  = running_q;
        evt    = 1'b0;
        wr_val = wdata_i;
        seed   = count_q;
        if (strb_i.reload) begin
            cnt_n = wdata_i;
            run_n = ctrl_i.run_en && (!div_zero || wdata_i != '0);
        end else if (strb_i.count) begin
            if (ctrl_i.run_en && ctrl_i.auto_rl && div_zero && wdata_i == '0) begin
                wr_val = reload_i;
            end
            cnt_n = wr_val;
            run_n = ctrl_i.run_en && (!div_zero || wr_val != '0);
        end else if (strb_i.ctrl) begin
            if (ctrl_new_i.run_en && ctrl_new_i.auto_rl && count_q == '0) begin
                seed = reload_i;
            end
            cnt_n = seed;
            run_n = ctrl_new_i.run_en && (!new_div_zero || seed != '0);
        end else if (tick_i) begin
            if (count_q > ONE) begin
                cnt_n = count_q - ONE;
            end else if (count_q == ONE) begin
                cnt_n = '0;
                evt   = 1'b1;
                if (!ctrl_i.auto_rl || (reload_i == '0 && div_zero)) begin
                    run_n = 1'b0;
                end
            end else if (ctrl_i.auto_rl && reload_i != '0) begin
                cnt_n = reload_i;
            end else begin
                evt = 1'b1;
                if (!ctrl_i.auto_rl) begin
                    run_n = 1'b0;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            count_q   <= '0;
            running_q <= 1'b0;
        end else begin
            count_q   <= cnt_n;
            running_q <= run_n;
        end
    end

    assign count_o    = count_q;
    assign running_o  = running_q;
    assign zero_evt_o = evt;

    // R8: counting never continues without run-enable
    assert_run_needs_en_R8: assert property (@(posedge clk) disable iff (rst)
        running_q |-> ctrl_i.run_en);

    // R5: one-shot reaching zero parks the counter
    assert_oneshot_stop_R5: assert property (@(posedge clk) disable iff (rst)
        (tick_i && !ctrl_i.auto_rl && count_q == ONE) |=> (!running_q && count_q == '0));

    // R6: the tick after zero restores the reload value
    assert_reload_R6: assert property (@(posedge clk) disable iff (rst)
        (tick_i && ctrl_i.auto_rl && count_q == '0 && reload_i != '0)
            |=> (count_q == $past(reload_i)));

    // R9: a zero reload write with zero divider halts the counter
    assert_zero_reload_R9: assert property (@(posedge clk) disable iff (rst)
        (strb_i.reload && ctrl_i.run_en && div_zero && wdata_i == '0) |=> !running_q);

endmodule

// File: rtl/pcd_regs.sv
module pcd_regs
    import pcd_timer_pkg::*;
#(
    parameter int unsigned DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  wr_strb_t          strb_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic              rd_en_i,
    input  slot_e             rd_slot_i,
    input  logic [DATA_W-1:0] count_i,
    input  logic              zero_evt_i,
    output ctrl_t             ctrl_o,
    output ctrl_t             ctrl_new_o,
    output logic [DATA_W-1:0] reload_o,
    output logic [DATA_W-1:0] rdata_o,
    output logic              irq_o
);
    ctrl_t             ctrl_q;
    logic [DATA_W-1:0] reload_q;
    logic              flag_q;
    logic              flag_clr;

    assign ctrl_new_o = ctrl_from_half(wdata_i[15:0]);
    assign flag_clr   = strb_i.flag && wdata_i[0];

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q   <= '0;
            reload_q <= '0;
            flag_q   <= 1'b0;
        end else begin
            if (strb_i.ctrl) begin
                ctrl_q <= ctrl_new_o;
            end
            if (strb_i.reload) begin
                reload_q <= wdata_i;
            end
            flag_q <= zero_evt_i || (flag_q && !flag_clr);
        end
    end

    always_comb begin
        rdata_o = '0;
        if (rd_en_i) begin
            case (rd_slot_i)
                SLOT_RELOAD: rdata_o = reload_q;
                SLOT_COUNT:  rdata_o = count_i;
                SLOT_CTRL:   rdata_o = DATA_W'(ctrl_to_half(ctrl_q));
                SLOT_FLAG:   rdata_o = DATA_W'(flag_q);
                default:     rdata_o = '0;
            endcase
        end
    end

    assign ctrl_o   = ctrl_q;
    assign reload_o = reload_q;
    assign irq_o    = flag_q && ctrl_q.irq_en;

    // R5: a zero event is always recorded
    assert_flag_set_R5: assert property (@(posedge clk) disable iff (rst)
        zero_evt_i |=> flag_q);

    // R4: write-one-to-clear drops the flag when no new event collides
    assert_flag_clear_R4: assert property (@(posedge clk) disable iff (rst)
        (flag_clr && !zero_evt_i) |=> !flag_q);

endmodule

// File: rtl/pcd_timer.sv
module pcd_timer
    import pcd_timer_pkg::*;
#(
    parameter int unsigned ADDR_W = 5,
    parameter int unsigned DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq
);
    localparam int unsigned SLOT_LSB = 2;

    logic              hit;
    slot_e             slot;
    wr_strb_t          strb;
    ctrl_t             ctrl, ctrl_new;
    logic [DATA_W-1:0] reload, count;
    logic              running, tick, zero_evt, restart;

    assign hit  = bus_sel && (bus_addr[1:0] == 2'b00) && ((bus_addr >> 4) == '0);
    assign slot = slot_e'(bus_addr[SLOT_LSB +: 2]);
    assign strb = strobes_for(hit, bus_wr, slot);
    assign restart = strb.reload || strb.count || strb.ctrl;

    pcd_prescale #(.W(DIV_W)) u_prescale (
        .clk       (clk),
        .rst       (rst),
        .run_i     (running),
        .restart_i (restart),
        .div_i     (ctrl.div),
        .tick_o    (tick)
    );

    pcd_count_core #(.CNT_W(DATA_W)) u_core (
        .clk        (clk),
        .rst        (rst),
        .tick_i     (tick),
        .strb_i     (strb),
        .wdata_i    (bus_wdata),
        .ctrl_i     (ctrl),
        .ctrl_new_i (ctrl_new),
        .reload_i   (reload),
        .count_o    (count),
        .running_o  (running),
        .zero_evt_o (zero_evt)
    );

    pcd_regs #(.DATA_W(DATA_W)) u_regs (
        .clk        (clk),
        .rst        (rst),
        .strb_i     (strb),
        .wdata_i    (bus_wdata),
        .rd_en_i    (hit && !bus_wr),
        .rd_slot_i  (slot),
        .count_i    (count),
        .zero_evt_i (zero_evt),
        .ctrl_o     (ctrl),
        .ctrl_new_o (ctrl_new),
        .reload_o   (reload),
        .rdata_o    (bus_rdata),
        .irq_o      (irq)
    );

    // R2: at most one register is written per access
    assert_one_slot_R2: assert property (@(posedge clk) disable iff (rst)
        $onehot0(strb));

    // R2: unmapped reads return zero
    assert_unmapped_zero_R2: assert property (@(posedge clk) disable iff (rst)
        (bus_sel && !bus_wr && !hit) |-> (bus_rdata == '0));

    // R4: no interrupt while interrupt-enable is clear
    assert_irq_gate_R4: assert property (@(posedge clk) disable iff (rst)
        !ctrl.irq_en |-> !irq);

endmodule

// File: tb/pcd_timer_tb.sv
module pcd_timer_tb_top;

    localparam logic [4:0] A_RELOAD = 5'h00;
    localparam logic [4:0] A_COUNT  = 5'h04;
    localparam logic [4:0] A_CTRL   = 5'h08;
    localparam logic [4:0] A_FLAG   = 5'h0C;
    localparam logic [4:0] A_HOLE0  = 5'h10;
    localparam logic [4:0] A_HOLE1  = 5'h14;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq;

    always #2.5 clk = ~clk;

    pcd_timer #(.ADDR_W(5), .DATA_W(32)) dut_i (
        .clk       (clk),
        .rst       (rst),
        .bus_sel   (bus_sel),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq       (irq)
    );

    typedef struct {
        bit          is_irq;
        logic [31:0] exp;
        string       tag;
    } exp_t;

    exp_t exp_q[$];
    event sample_ev;
    int   n_chk = 0;
    int   n_fail = 0;
    bit   done = 0;

    // monitor: pops the expected item and compares with what the ports show
    always begin
        exp_t        it;
        logic [31:0] act;
        @(sample_ev);
        it  = exp_q.pop_front();
        act = it.is_irq ? {31'b0, irq} : bus_rdata;
        n_chk++;
        if (act !== it.exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", it.tag, act, it.exp);
        end
    end

    task automatic wr_reg(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    endtask

    task automatic rd_chk(input logic [4:0] a, input logic [31:0] e, input string tag);
        exp_t it;
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a; bus_wdata = '0;
        it.is_irq = 1'b0; it.exp = e; it.tag = tag;
        exp_q.push_back(it);
        #1 -> sample_ev;
    endtask

    task automatic irq_chk(input logic e, input string tag);
        exp_t it;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
        it.is_irq = 1'b1; it.exp = {31'b0, e}; it.tag = tag;
        exp_q.push_back(it);
        #1 -> sample_ev;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            bus_sel = 1'b0; bus_wr = 1'b0;
        end
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual running expected finished");
            summary();
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        rd_chk(A_RELOAD, 32'h0, "R1 reload");
        rd_chk(A_COUNT,  32'h0, "R1 count");
        rd_chk(A_CTRL,   32'h0, "R1 ctrl");
        rd_chk(A_FLAG,   32'h0, "R1 flag");
        irq_chk(1'b0, "R1 irq");

        // R2 map, field masking, holes; R12 and R8 while disabled
        wr_reg(A_CTRL, 32'hABCD_0304);
        rd_chk(A_CTRL, 32'h0000_0304, "R2 ctrl fields");
        wr_reg(A_HOLE1, 32'h0000_0077);
        rd_chk(A_HOLE0, 32'h0, "R2 hole read");
        rd_chk(A_RELOAD, 32'h0, "R2 hole write ignored");
        wr_reg(A_RELOAD, 32'd5);
        rd_chk(A_COUNT, 32'd5, "R12 reload sets count");
        idle(3);
        rd_chk(A_COUNT, 32'd5, "R8 disabled holds");

        // R3 divider 1, one-shot; R5 stop; R4 gating and clear
        wr_reg(A_CTRL, 32'h0000_0105);
        rd_chk(A_COUNT, 32'd5, "R3 first cycle");
        rd_chk(A_COUNT, 32'd5, "R3 before tick");
        rd_chk(A_COUNT, 32'd4, "R3 first tick");
        rd_chk(A_COUNT, 32'd4, "R3 hold between ticks");
        idle(5);
        rd_chk(A_FLAG, 32'd0, "R5 no early event");
        rd_chk(A_FLAG, 32'd1, "R5 event at zero");
        irq_chk(1'b1, "R4 irq asserted");
        rd_chk(A_COUNT, 32'd0, "R5 count zero");
        idle(1);
        rd_chk(A_COUNT, 32'd0, "R5 stays at zero");
        wr_reg(A_CTRL, 32'h0000_0100);
        irq_chk(1'b0, "R4 gated off");
        rd_chk(A_FLAG, 32'd1, "R4 flag kept when gated");
        wr_reg(A_CTRL, 32'h0000_0104);
        irq_chk(1'b1, "R4 gated on");
        wr_reg(A_FLAG, 32'd1);
        irq_chk(1'b0, "R4 clear drops irq");
        rd_chk(A_FLAG, 32'd0, "R4 flag cleared");

        // R6 auto-reload, divider 0, reload 2
        wr_reg(A_CTRL, 32'h0);
        wr_reg(A_RELOAD, 32'd2);
        wr_reg(A_CTRL, 32'h0000_0007);
        rd_chk(A_COUNT, 32'd2, "R6 start");
        rd_chk(A_COUNT, 32'd1, "R6 dec");
        rd_chk(A_FLAG,  32'd1, "R6 event at zero");
        rd_chk(A_COUNT, 32'd2, "R6 reload after zero");
        rd_chk(A_COUNT, 32'd1, "R6 continues");
        wr_reg(A_CTRL, 32'h0);
        wr_reg(A_FLAG, 32'd1);

        // R7 reload 0, divider 1: event every tick
        wr_reg(A_RELOAD, 32'd0);
        wr_reg(A_CTRL, 32'h0000_0107);
        idle(2);
        wr_reg(A_FLAG, 32'd1);
        rd_chk(A_FLAG, 32'd0, "R7 cleared between ticks");
        rd_chk(A_FLAG, 32'd1, "R7 event again next tick");
        irq_chk(1'b1, "R7 irq");
        wr_reg(A_CTRL, 32'h0);
        wr_reg(A_FLAG, 32'd1);

        // R7 reload 0, divider 0: single event then stop
        wr_reg(A_COUNT, 32'd1);
        wr_reg(A_CTRL, 32'h0000_0003);
        rd_chk(A_FLAG, 32'd0, "R7 before zero");
        rd_chk(A_FLAG, 32'd1, "R7 event at zero");
        wr_reg(A_FLAG, 32'd1);
        idle(2);
        rd_chk(A_FLAG, 32'd0, "R7 stopped after event");
        rd_chk(A_COUNT, 32'd0, "R7 count zero");
        wr_reg(A_CTRL, 32'h0);

        // R9 zero reload write while running, divider 0
        wr_reg(A_RELOAD, 32'd10);
        wr_reg(A_CTRL, 32'h0000_0005);
        idle(2);
        wr_reg(A_RELOAD, 32'd0);
        idle(3);
        rd_chk(A_FLAG, 32'd0, "R9 no event");
        rd_chk(A_COUNT, 32'd0, "R9 count zero");

        // R10 zero count write, one-shot
        wr_reg(A_RELOAD, 32'd10);
        idle(2);
        wr_reg(A_COUNT, 32'd0);
        idle(3);
        rd_chk(A_FLAG, 32'd0, "R10 one-shot no event");
        rd_chk(A_COUNT, 32'd0, "R10 one-shot count zero");

        // R10 zero count write, auto-reload with reload 4
        wr_reg(A_CTRL, 32'h0);
        wr_reg(A_RELOAD, 32'd4);
        wr_reg(A_CTRL, 32'h0000_0003);
        wr_reg(A_COUNT, 32'd0);
        rd_chk(A_COUNT, 32'd4, "R10 auto takes reload");
        rd_chk(A_COUNT, 32'd3, "R10 auto keeps running");
        rd_chk(A_FLAG, 32'd0, "R10 auto no event");

        // R11 control write with count 0
        wr_reg(A_CTRL, 32'h0);
        wr_reg(A_RELOAD, 32'd6);
        wr_reg(A_COUNT, 32'd0);
        wr_reg(A_CTRL, 32'h0000_0001);
        idle(2);
        rd_chk(A_COUNT, 32'd0, "R11 one-shot stays stopped");
        rd_chk(A_FLAG, 32'd0, "R11 one-shot no event");
        wr_reg(A_CTRL, 32'h0000_0003);
        rd_chk(A_COUNT, 32'd6, "R11 auto seeds from reload");
        rd_chk(A_COUNT, 32'd5, "R11 auto runs");

        idle(2);
        done = 1;
        summary();
        $finish;
    end

endmodule